// File: doc/BRIEF.md
# Key-Protected DRAM Controller Register File

This block holds the 32-bit control and status words of a DRAM controller and decides, write by write, whether a store may land. A lock register at word 0 holds one of three states. Software enters the unlocked state by writing an unlock key there. A second key freezes the block until reset. Any other value drops it back to the soft-locked state. Status, interrupt, error-capture and per-port monitor words bypass the lock and always accept data. The remaining control words accept data only while unlocked.

The main configuration word keeps its reserved bits at zero. It always reports page matching as enabled and always carries the live DRAM size code from a strap input, whatever was written. The bus is a simple single-cycle register port. `addr` is a word index, equal to the byte offset divided by four, and covers 0x500 bytes of space. Reads are combinational and have no side effects. A one-cycle flag reports each write that the lock refused.

Top module: `mcreg_top`

## Requirements
- R1: A write to word 0 (byte 0x00) sets the lock state. 0x1688A8A8 selects unlocked, 0xDEADDEAD selects hard-locked, and any other value selects soft-locked. Word 0 reads 0x00000000 when soft-locked, 0x00000001 when unlocked and 0x00000002 when hard-locked.
- R2: In every lock state, a write to one of the open words stores the data unchanged. The open words are at byte offsets 0x04, 0x08, 0x0C, 0x18, 0x1C, 0x78, 0x7C, 0x94, 0xD4, 0xD8, 0xDC, 0xE0, 0xE4, 0xF4, 0xF8 and 0x10C, plus for each port n in 0..5 the three words at 0x240+n*0x80, +0x04 and +0x08.
- R3: While hard-locked, writes to word 0, to the configuration word and to the guarded words are ignored. Only reset leaves the hard-locked state.
- R4: While soft-locked, writes to the configuration word and to the guarded words are ignored. A write to word 0 still takes effect.
- R5: In the configuration word (byte 0x10), the bits set in 0xFFFF2082 always read as zero.
- R6: In the configuration word, bit 5 always reads 1 and bits 4:2 always equal the current `strap_size` input, whatever was written.
- R7: While unlocked, a write to the configuration word stores the bits set in 0x0000DF41, including scramble enable (bit 8) and ECC enable (bit 6). A write to a guarded word stores all 32 bits. The guarded words are at byte offsets 0x14 and 0x80.
- R8: After reset, every open and guarded word reads zero and the configuration word reads only its forced fields. Word 0 reads 1 if `strap_unlocked` was high during reset and 0 otherwise.
- R9: A read of any other word index, including indices at or beyond 0x140, returns zero. A write there has no effect.
- R10: `wr_blocked` is high for exactly the cycle after a clock edge that took a write refused under R3 or R4. It stays low after open, unmapped and accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_unlocked | input | 1 | Lock state after reset: 1 = unlocked |
| strap_size | input | 3 | DRAM size code, 0 = 256 MiB up to 5 = 8 GiB |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | 9 | Word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| wr_blocked | output | 1 | Pulse after a write refused by the lock |

## Verification
The lock decision and the store are resolved in the same cycle as the write. A write of the hard-lock key to word 0 therefore competes with the unlock key written in the very next cycle. The bench issues these back to back and expects the second write to be refused and flagged. The bench also changes `strap_size` between two reads of the configuration word without writing it in between. It judges the forced field against the new strap value while the writable bits stay as last stored.

// File: rtl/mcreg_pkg.sv
package mcreg_pkg;

   typedef enum logic [1:0] {
      LK_SOFT = 2'd0,
      LK_OPEN = 2'd1,
      LK_HARD = 2'd2
   } lock_e;

   localparam logic [31:0] KEY_OPEN = 32'h1688_A8A8;
   localparam logic [31:0] KEY_HARD = 32'hDEAD_DEAD;

   localparam logic [31:0] CONF_RSVD    = 32'hFFFF_2082;
   localparam logic [31:0] CONF_WR_MASK = 32'h0000_DF41;
   localparam int unsigned CONF_PAGE_BIT = 5;
   localparam int unsigned CONF_SIZE_LSB = 2;

   localparam int unsigned N_FIXED_OPEN = 16;
   localparam int unsigned FIXED_OPEN_WORDS [N_FIXED_OPEN] = '{
      32'h01, 32'h02, 32'h03, 32'h06, 32'h07, 32'h1E, 32'h1F, 32'h25,
      32'h35, 32'h36, 32'h37, 32'h38, 32'h39, 32'h3D, 32'h3E, 32'h43
   };

endpackage

// File: rtl/mcreg_addr_map.sv
module mcreg_addr_map #(
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned SPACE_WORDS = 320,
   parameter int unsigned NUM_PORTS   = 6,
   parameter int unsigned MON_WORDS   = 3,
   parameter int unsigned MON_BASE    = 32'h90,
   parameter int unsigned MON_STRIDE  = 32'h20,
   parameter int unsigned PROT_WORD   = 0,
   parameter int unsigned CONF_WORD   = 4,
   parameter int unsigned CTRL_WORD   = 5,
   parameter int unsigned TEST_WORD   = 32'h20,
   parameter int unsigned N_SLOT      = 36,
   parameter int unsigned SLOT_W      = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_prot,
   output logic              hit_conf,
   output logic              hit_open,
   output logic              hit_guard,
   output logic [SLOT_W-1:0] slot
);
   import mcreg_pkg::*;

   localparam int unsigned N_OPEN = N_FIXED_OPEN + NUM_PORTS * MON_WORDS;

   if (MON_BASE + (NUM_PORTS - 1) * MON_STRIDE + MON_WORDS > SPACE_WORDS) begin : g_chk_space
      $error("monitor words exceed the address space");
   end
   if (MON_WORDS > MON_STRIDE) begin : g_chk_stride
      $error("monitor stride smaller than monitor group");
   end
   if (N_SLOT != N_OPEN + 2) begin : g_chk_slots
      $error("slot count does not match the open and guarded words");
   end

   always_comb begin
      hit_prot  = (addr == ADDR_W'(PROT_WORD));
      hit_conf  = (addr == ADDR_W'(CONF_WORD));
      hit_open  = 1'b0;
      hit_guard = 1'b0;
      slot      = '0;
      for (int i = 0; i < int'(N_FIXED_OPEN); i++) begin
         if (addr == ADDR_W'(FIXED_OPEN_WORDS[i])) begin
            hit_open = 1'b1;
            slot     = SLOT_W'(i);
         end
      end
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
         for (int w = 0; w < int'(MON_WORDS); w++) begin
            if (addr == ADDR_W'(int'(MON_BASE) + p * int'(MON_STRIDE) + w)) begin
               hit_open = 1'b1;
               slot     = SLOT_W'(int'(N_FIXED_OPEN) + p * int'(MON_WORDS) + w);
            end
         end
      end
      if (addr == ADDR_W'(CTRL_WORD)) begin
         hit_guard = 1'b1;
         slot      = SLOT_W'(N_OPEN);
      end
      if (addr == ADDR_W'(TEST_WORD)) begin
         hit_guard = 1'b1;
         slot      = SLOT_W'(N_OPEN + 1);
      end
   end

endmodule

// File: rtl/mcreg_lock.sv
module mcreg_lock (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               strap_unlocked,
   input  logic               key_we,
   input  logic [31:0]        key,
   output mcreg_pkg::lock_e   state
);
   import mcreg_pkg::*;

   lock_e next;

   always_comb begin
      next = state;
      if (key_we && state != LK_HARD) begin
         if (key == KEY_OPEN)      next = LK_OPEN;
         else if (key == KEY_HARD) next = LK_HARD;
         else                      next = LK_SOFT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= strap_unlocked ? LK_OPEN : LK_SOFT;
      else        state <= next;
   end

endmodule

// File: rtl/mcreg_top.sv
module mcreg_top #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned SPACE_WORDS = 320,
   parameter int unsigned NUM_PORTS   = 6,
   parameter int unsigned MON_WORDS   = 3,
   parameter int unsigned SIZE_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_unlocked,
   input  logic [SIZE_W-1:0] strap_size,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              wr_blocked
);
   import mcreg_pkg::*;

   localparam int unsigned N_OPEN = N_FIXED_OPEN + NUM_PORTS * MON_WORDS;
   localparam int unsigned N_SLOT = N_OPEN + 2;
   localparam int unsigned SLOT_W = $clog2(N_SLOT);

   if (DATA_W != 32) begin : g_chk_width
      $error("register file is defined for 32-bit words");
   end
   if (SPACE_WORDS > (1 << ADDR_W)) begin : g_chk_addr
      $error("address port too narrow for the space");
   end
   if (CONF_SIZE_LSB + SIZE_W > CONF_PAGE_BIT) begin : g_chk_size
      $error("size field overlaps page-matching bit");
   end

   logic              hit_prot, hit_conf, hit_open, hit_guard;
   logic [SLOT_W-1:0] slot;
   lock_e             lock_state;
   logic [DATA_W-1:0] slot_q [N_SLOT];
   logic [DATA_W-1:0] conf_q;
   logic [DATA_W-1:0] conf_view;
   logic              may_guard, slot_we, conf_we, refuse;

   mcreg_addr_map #(
      .ADDR_W(ADDR_W), .SPACE_WORDS(SPACE_WORDS), .NUM_PORTS(NUM_PORTS),
      .MON_WORDS(MON_WORDS), .MON_BASE(32'h90), .MON_STRIDE(32'h20),
      .PROT_WORD(0), .CONF_WORD(4), .CTRL_WORD(5), .TEST_WORD(32'h20),
      .N_SLOT(N_SLOT), .SLOT_W(SLOT_W)
   ) u_map (
      .addr(addr), .hit_prot(hit_prot), .hit_conf(hit_conf),
      .hit_open(hit_open), .hit_guard(hit_guard), .slot(slot)
   );

   mcreg_lock u_lock (
      .clk(clk), .rst_n(rst_n), .strap_unlocked(strap_unlocked),
      .key_we(wr_en && hit_prot), .key(wdata), .state(lock_state)
   );

   assign may_guard = (lock_state == LK_OPEN);
   assign slot_we   = wr_en && (hit_open || (hit_guard && may_guard));
   assign conf_we   = wr_en && hit_conf && may_guard;
   assign refuse    = wr_en && ((hit_prot && lock_state == LK_HARD) ||
                                ((hit_guard || hit_conf) && !may_guard));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(N_SLOT); i++) slot_q[i] <= '0;
         conf_q     <= '0;
         wr_blocked <= 1'b0;
      end else begin
         for (int i = 0; i < int'(N_SLOT); i++) begin
            if (slot_we && slot == SLOT_W'(i)) slot_q[i] <= wdata;
         end
         if (conf_we) conf_q <= wdata & CONF_WR_MASK;
         wr_blocked <= refuse;
      end
   end

   always_comb begin
      conf_view = (conf_q & CONF_WR_MASK) & ~CONF_RSVD;
      conf_view[CONF_PAGE_BIT] = 1'b1;
      conf_view[CONF_SIZE_LSB +: SIZE_W] = strap_size;
   end

   always_comb begin
      if (hit_prot)                    rdata = DATA_W'(lock_state);
      else if (hit_conf)               rdata = conf_view;
      else if (hit_open || hit_guard)  rdata = slot_q[slot];
      else                             rdata = '0;
   end

endmodule

// File: rtl/mcreg_checker.sv
module mcreg_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [8:0]  addr,
   input logic [2:0]  strap_size,
   input logic [31:0] rdata,
   input logic        wr_blocked,
   input logic [1:0]  lock_state,
   input logic [31:0] conf_q
);

   AST_PROT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 9'd0) |-> (rdata <= 32'd2)); // R1

   AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_state == 2'd2) |=> (lock_state == 2'd2)); // R3

   AST_SOFT_CONF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 9'd4 && lock_state != 2'd1) |=> $stable(conf_q)); // R4

   AST_CONF_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 9'd4) |-> ((rdata & 32'hFFFF_2082) == 32'd0)); // R5

   AST_CONF_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 9'd4) |-> (rdata[5] && rdata[4:2] == strap_size)); // R6

   AST_BLOCK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_blocked |-> $past(wr_en)); // R10

   AST_BLOCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_blocked && !$past(wr_en, 1)) |-> 1'b0); // R10

endmodule

bind mcreg_top mcreg_checker u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
   .strap_size(strap_size), .rdata(rdata), .wr_blocked(wr_blocked),
   .lock_state(lock_state), .conf_q(conf_q)
);

// File: tb/mcreg_top_bench.sv
module mcreg_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_unlocked = 1'b0;
   logic [2:0]  strap_size = 3'd2;
   logic        wr_en = 1'b0;
   logic [8:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        wr_blocked;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [31:0] mem [512];
   logic [31:0] conf_w;
   logic [1:0]  lk;

   always #10 clk = ~clk;

   mcreg_top u_mcreg_top (
      .clk(clk), .rst_n(rst_n), .strap_unlocked(strap_unlocked),
      .strap_size(strap_size), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .wr_blocked(wr_blocked)
   );

   function automatic bit is_open(int a);
      int fixed [16] = '{'h01, 'h02, 'h03, 'h06, 'h07, 'h1E, 'h1F, 'h25,
                         'h35, 'h36, 'h37, 'h38, 'h39, 'h3D, 'h3E, 'h43};
      foreach (fixed[i]) if (a == fixed[i]) return 1;
      for (int p = 0; p < 6; p++)
         for (int w = 0; w < 3; w++)
            if (a == 'h90 + p * 'h20 + w) return 1;
      return 0;
   endfunction

   function automatic bit is_guard(int a);
      return a == 5 || a == 'h20;
   endfunction

   function automatic logic [31:0] exp_read(int a);
      if (a == 0) return {30'd0, lk};
      if (a == 4) return conf_w | 32'h20 | ({29'd0, strap_size} << 2);
      if (is_open(a) || is_guard(a)) return mem[a];
      return 32'd0;
   endfunction

   function automatic bit model_write(int a, logic [31:0] d);
      if (is_open(a)) begin mem[a] = d; return 0; end
      if (a == 0) begin
         if (lk == 2'd2) return 1;
         lk = (d == 32'h1688A8A8) ? 2'd1 : (d == 32'hDEADDEAD) ? 2'd2 : 2'd0;
         return 0;
      end
      if (a == 4 || is_guard(a)) begin
         if (lk != 2'd1) return 1;
         if (a == 4) conf_w = d & 32'h0000DF41;
         else mem[a] = d;
         return 0;
      end
      return 0;
   endfunction

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic do_rst(bit unl);
      @(negedge clk);
      rst_n = 0; wr_en = 0; strap_unlocked = unl;
      repeat (3) @(negedge clk);
      rst_n = 1;
      foreach (mem[i]) mem[i] = '0;
      conf_w = '0;
      lk = unl ? 2'd1 : 2'd0;
   endtask

   task automatic do_wr(int a, logic [31:0] d, string req);
      bit eb;
      @(negedge clk);
      addr = 9'(a); wdata = d; wr_en = 1;
      eb = model_write(a, d);
      @(negedge clk);
      wr_en = 0;
      chk({req, " R10 blocked flag"}, {31'd0, wr_blocked}, {31'd0, eb});
   endtask

   task automatic do_rd(int a, string req);
      @(negedge clk);
      addr = 9'(a);
      #1;
      chk(req, rdata, exp_read(a));
   endtask

   function automatic int pick_addr();
      int fixed [16] = '{'h01, 'h02, 'h03, 'h06, 'h07, 'h1E, 'h1F, 'h25,
                         'h35, 'h36, 'h37, 'h38, 'h39, 'h3D, 'h3E, 'h43};
      case ($urandom_range(0, 6))
         0: return 0;
         1: return 4;
         2: return ($urandom_range(0, 1) != 0) ? 5 : 'h20;
         3: return fixed[$urandom_range(0, 15)];
         4: return 'h90 + $urandom_range(0, 5) * 'h20 + $urandom_range(0, 2);
         5: return $urandom_range(320, 511);
         default: return $urandom_range(0, 319);
      endcase
   endfunction

   function automatic logic [31:0] pick_data(int a);
      if (a == 0) begin
         case ($urandom_range(0, 3))
            0, 1: return 32'h1688A8A8;
            default: return $urandom;
         endcase
      end
      return $urandom;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      do_rst(0);
      // R8 reset state
      do_rd(0, "R8 prot after reset");
      do_rd(4, "R8 conf after reset");
      do_rd('h05, "R8 guarded zero");
      do_rd('h92, "R8 monitor zero");
      chk("R8 R10 no block after reset", {31'd0, wr_blocked}, 32'd0);
      // R4 soft lock refuses guarded words
      do_wr(4, 32'hFFFF_FFFF, "R4 conf soft");
      do_rd(4, "R4 conf unchanged");
      do_wr('h20, 32'h1234_5678, "R4 guard soft");
      do_rd('h20, "R4 guard unchanged");
      // R2 open words in soft lock
      do_wr('h43, 32'hCAFE_0001, "R2 open soft");
      do_rd('h43, "R2 open soft readback");
      // R1 unlock
      do_wr(0, 32'h1688A8A8, "R1 unlock");
      do_rd(0, "R1 unlocked code");
      // R5 R6 R7 config masking
      do_wr(4, 32'hFFFF_FFFF, "R7 conf all ones");
      do_rd(4, "R5 R6 R7 conf masked");
      do_wr(4, 32'h0000_0000, "R7 conf zeros");
      do_rd(4, "R6 conf forced with zeros");
      do_wr(4, 32'h0000_0140, "R7 scramble and ecc");
      strap_size = 3'd5;
      do_rd(4, "R6 strap follows live");
      do_wr(5, 32'hA5A5_5A5A, "R7 ctrl word");
      do_rd(5, "R7 ctrl readback");
      // R9 unmapped
      do_wr('h11, 32'hFFFF_FFFF, "R9 unmapped write");
      do_rd('h11, "R9 unmapped read");
      do_wr(400, 32'h1111_2222, "R9 beyond space");
      do_rd(400, "R9 beyond space read");
      // R1 other value soft-locks
      do_wr(0, 32'h0000_0001, "R1 other value");
      do_rd(0, "R1 soft code");
      do_wr(0, 32'h1688A8A8, "R1 unlock again");
      // random phase
      for (int k = 0; k < 600; k++) begin
         int a;
         a = pick_addr();
         if ($urandom_range(0, 3) == 0) do_rd(a, "R2 R4 R7 R9 random read");
         else begin
            do_wr(a, pick_data(a), "R1 R2 R4 random write");
            do_rd(a, "R1 R2 R4 R7 random readback");
         end
         if ($urandom_range(0, 15) == 0) strap_size = 3'($urandom_range(0, 5));
      end
      // R3 hard lock, unlock key right after
      do_wr(0, 32'h1688A8A8, "R1 unlock before hard");
      do_wr(0, 32'hDEADDEAD, "R1 hard key");
      do_wr(0, 32'h1688A8A8, "R3 unlock refused");
      do_rd(0, "R3 still hard");
      do_wr(4, 32'h0000_0041, "R3 conf refused");
      do_rd(4, "R3 conf unchanged");
      do_wr('h20, 32'h7777_0000, "R3 guard refused");
      do_rd('h20, "R3 guard unchanged");
      do_wr('h1E, 32'h0BAD_F00D, "R2 open in hard");
      do_rd('h1E, "R2 open hard readback");
      for (int k = 0; k < 200; k++) begin
         int a;
         a = pick_addr();
         do_wr(a, pick_data(a), "R2 R3 random hard");
         do_rd(a, "R2 R3 random hard readback");
      end
      // R8 reset leaves hard lock, strap unlocked
      do_rst(1);
      do_rd(0, "R8 prot strap unlocked");
      do_rd('h1E, "R8 open cleared");
      do_rd(4, "R8 conf cleared");
      do_wr('h80 >> 2, 32'h0000_00FF, "R7 test word unlocked");
      do_rd('h80 >> 2, "R7 test word readback");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule